// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Acknowledge Unit

This block joins two eight-input priority interrupt controllers into one sixteen-line interrupt system. Lines 0 to 7 feed the primary controller and lines 8 to 15 feed the secondary. The secondary's winning request is folded into one input of the primary, the cascade input. The primary's winner drives a single interrupt line toward the CPU.

When the CPU issues a one-cycle acknowledge strobe, the block resolves the winner across both levels and marks it in service. It then returns an eight-bit vector and the resolved line number (0 to 15), with a valid flag, one clock later. When a level has nothing to deliver, it substitutes its own spurious line. Base vectors, per-line masks and the nesting mode come from inputs that stand in for programmed controller registers. End-of-interrupt strobes, one for each controller, retire in-service bits.

Top module: `cascade_irq_ack`

## Requirements
- R1: After reset, `int_o` and `vld_o` are 0, and no line is pending or in service.
- R2: A request is taken on a rising edge only. A line that rises before a clock edge makes `int_o` high after that edge. A line that stays high raises no new request after its first one has been acknowledged.
- R3: An acknowledge of primary line n (n not 2) sets `vld_o` in the next cycle, with `line_o` = n and `vec_o` = {`pri_base_i`[7:3], n}. Base bits 2:0 are ignored.
- R4: Priority is fixed, and a lower index wins. A line in service on a controller blocks requests of equal or higher index on that controller until it is retired.
- R5: A rising edge on secondary line 8+k sets the cascade input of the primary one clock after the secondary request is taken, so `int_o` rises after the second clock edge. Its acknowledge returns `line_o` = 8+k and `vec_o` = {`sec_base_i`[7:3], k}.
- R6: An acknowledge while the primary has no winner returns `line_o` = 7 and `vec_o` = {`pri_base_i`[7:3], 7}.
- R7: An acknowledge that selects the cascade input while the secondary has no winner returns `line_o` = 15 and `vec_o` = {`sec_base_i`[7:3], 7}.
- R8: With `nest_i` low, an in-service cascade input blocks further secondary requests. With `nest_i` high, that in-service bit is left out of the primary's priority comparison, so a higher-priority secondary request nests and is delivered.
- R9: Request line 2 has no effect. Primary input 2 is driven only by the secondary.
- R10: `eoi_pri_i` or `eoi_sec_i` clears the lowest-index in-service bit of that controller, and this can let a blocked request win.
- R11: `int_o` is high exactly when the primary has a winner. It is re-evaluated after each acknowledge, and it falls when nothing else is pending.
- R12: `vld_o` is high only in the cycle after an `ack_i` pulse.
- R13: A line whose `mask_i` bit is 1 stays pending but does not compete. Clearing the mask bit lets it win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Request lines; line n reaches controller n/8, input n mod 8 |
| mask_i | input | 16 | Per-line mask, 1 = excluded from arbitration |
| nest_i | input | 1 | Primary nesting mode: ignore in-service cascade bit |
| pri_base_i | input | 8 | Primary vector base, bits 7:3 used |
| sec_base_i | input | 8 | Secondary vector base, bits 7:3 used |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| eoi_pri_i | input | 1 | Retire lowest in-service bit on the primary |
| eoi_sec_i | input | 1 | Retire lowest in-service bit on the secondary |
| int_o | output | 1 | Interrupt request to the CPU |
| vld_o | output | 1 | Vector and line number valid |
| vec_o | output | 8 | Resolved vector |
| line_o | output | 4 | Resolved line number 0 to 15 |

## Verification
The bench builds the block with its default cascade input, primary input 2. This is the wiring under which line 2 is unused and the secondary is reported as lines 8 to 15. With that input fixed, each route to a vector can be reached by directed stimulus: a direct primary winner, a cascaded secondary winner, and a spurious result on each level. A spurious secondary result is reached by masking a secondary line after its cascade request has been raised. Both nesting settings are run against the same sequence, so the blocking and nesting outcomes can be compared.

// File: rtl/cascade_irq_ack.sv
module cascade_irq_ack #(
  parameter int CASCADE_PIN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_i,
  input  logic [15:0] mask_i,
  input  logic        nest_i,
  input  logic [7:0]  pri_base_i,
  input  logic [7:0]  sec_base_i,
  input  logic        ack_i,
  input  logic        eoi_pri_i,
  input  logic        eoi_sec_i,
  output logic        int_o,
  output logic        vld_o,
  output logic [7:0]  vec_o,
  output logic [3:0]  line_o
);
  localparam logic [2:0] CAS  = 3'(CASCADE_PIN);
  localparam logic [2:0] SPUR = 3'd7;

  logic [15:0] last_q;
  logic [7:0]  pirr, pisr, sirr, sisr;
  logic        vld_q;
  logic [7:0]  vec_q;
  logic [3:0]  line_q;

  function automatic logic [3:0] first8(input logic [7:0] v);
    logic [3:0] r;
    r = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) r = 4'(i);
    return r;
  endfunction

  logic [15:0] edge_w;
  logic [3:0]  s_idx, s_cur, p_idx, p_cur;
  logic        s_win, p_win, ack_cas, sec_take;
  logic [7:0]  p_set, p_clr, s_clr, p_eoi, s_eoi;

  assign edge_w   = irq_i & ~last_q;
  assign s_idx    = first8(sirr & ~mask_i[15:8]);
  assign s_cur    = first8(sisr);
  assign s_win    = s_idx < s_cur;
  assign p_idx    = first8(pirr & ~mask_i[7:0]);
  assign p_cur    = first8(pisr & ~(nest_i ? (8'b1 << CAS) : 8'b0));
  assign p_win    = p_idx < p_cur;
  assign ack_cas  = ack_i & p_win & (p_idx[2:0] == CAS);
  assign sec_take = ack_cas & s_win;

  always_comb begin
    p_set = edge_w[7:0];
    p_set[CAS] = s_win & ~ack_cas;
  end

  assign p_clr = (ack_i & p_win) ? (8'b1 << p_idx[2:0]) : 8'b0;
  assign s_clr = sec_take ? (8'b1 << s_idx[2:0]) : 8'b0;
  assign p_eoi = eoi_pri_i ? (pisr & (~pisr + 8'd1)) : 8'b0;
  assign s_eoi = eoi_sec_i ? (sisr & (~sisr + 8'd1)) : 8'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      pirr   <= '0;
      pisr   <= '0;
      sirr   <= '0;
      sisr   <= '0;
      vld_q  <= 1'b0;
      vec_q  <= '0;
      line_q <= '0;
    end else begin
      last_q <= irq_i;
      pirr   <= (pirr & ~p_clr) | p_set;
      pisr   <= (pisr & ~p_eoi) | p_clr;
      sirr   <= (sirr & ~s_clr) | edge_w[15:8];
      sisr   <= (sisr & ~s_eoi) | s_clr;
      vld_q  <= ack_i;
      if (ack_i) begin
        if (!p_win) begin
          vec_q  <= {pri_base_i[7:3], SPUR};
          line_q <= {1'b0, SPUR};
        end else if (p_idx[2:0] != CAS) begin
          vec_q  <= {pri_base_i[7:3], p_idx[2:0]};
          line_q <= {1'b0, p_idx[2:0]};
        end else if (s_win) begin
          vec_q  <= {sec_base_i[7:3], s_idx[2:0]};
          line_q <= {1'b1, s_idx[2:0]};
        end else begin
          vec_q  <= {sec_base_i[7:3], SPUR};
          line_q <= {1'b1, SPUR};
        end
      end
    end
  end

  assign int_o  = p_win;
  assign vld_o  = vld_q;
  assign vec_o  = vec_q;
  assign line_o = line_q;

  a_r12_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vld_o);
  a_r12_no_vld_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vld_o);
  a_r3_vec_matches_line: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (vec_o[2:0] == line_o[2:0]));
  a_r6_spurious_primary: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> (line_o == 4'd7 && vec_o == {$past(pri_base_i[7:3]), 3'd7}));
  a_r5_secondary_base: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && $past(rst_n)) |=> (!line_o[3] || vec_o[7:3] == $past(sec_base_i[7:3])));
  a_r10_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pri_i && !ack_i && pisr != 8'd0) |=> ($countones(pisr) == $countones($past(pisr)) - 1));
endmodule

// File: tb/test_cascade_irq_ack.sv
module test_cascade_irq_ack;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_i, mask_i;
  logic        nest_i, ack_i, eoi_pri_i, eoi_sec_i;
  logic [7:0]  pri_base_i, sec_base_i;
  logic        int_o, vld_o;
  logic [7:0]  vec_o;
  logic [3:0]  line_o;
  int n_cmp = 0;
  int n_err = 0;

  localparam logic [7:0] PB = 8'h23;
  localparam logic [7:0] SB = 8'h75;

  always #2.5 clk = ~clk;

  cascade_irq_ack i_cascade_irq_ack (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .mask_i(mask_i), .nest_i(nest_i),
    .pri_base_i(pri_base_i), .sec_base_i(sec_base_i), .ack_i(ack_i),
    .eoi_pri_i(eoi_pri_i), .eoi_sec_i(eoi_sec_i), .int_o(int_o), .vld_o(vld_o),
    .vec_o(vec_o), .line_o(line_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic nest);
    rst_n = 1'b0; irq_i = '0; mask_i = '0; nest_i = nest; ack_i = 1'b0;
    eoi_pri_i = 1'b0; eoi_sec_i = 1'b0; pri_base_i = PB; sec_base_i = SB;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic do_ack;
    ack_i = 1'b1;
    tick(1);
    ack_i = 1'b0;
  endtask

  task automatic eoi_pri;
    eoi_pri_i = 1'b1;
    tick(1);
    eoi_pri_i = 1'b0;
  endtask

  task automatic expect_ack(input string req, input logic [3:0] ln, input logic [7:0] vec);
    do_ack();
    chk(req, vld_o, 1'b1);
    chk(req, line_o, ln);
    chk(req, vec_o, vec);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1 int", int_o, 1'b0);
    chk("R1 vld", vld_o, 1'b0);
    tick(3);
    chk("R1 idle int", int_o, 1'b0);
    chk("R12 idle vld", vld_o, 1'b0);
  endtask

  task automatic t_primary;
    do_reset(1'b0);
    irq_i[5] = 1'b1;
    tick(1);
    chk("R2 edge raises int", int_o, 1'b1);
    expect_ack("R3 primary ack", 4'd5, (PB & 8'hf8) | 8'd5);
    chk("R11 int falls after ack", int_o, 1'b0);
    tick(1);
    chk("R12 vld one cycle", vld_o, 1'b0);
    eoi_pri();
    tick(2);
    chk("R2 held level no rerequest", int_o, 1'b0);
    irq_i[5] = 1'b0;
    tick(1);
    irq_i[5] = 1'b1;
    tick(1);
    chk("R2 new edge", int_o, 1'b1);
  endtask

  task automatic t_priority;
    do_reset(1'b0);
    irq_i[6] = 1'b1; irq_i[3] = 1'b1;
    tick(1);
    expect_ack("R4 lower index wins", 4'd3, (PB & 8'hf8) | 8'd3);
    chk("R4 in-service blocks", int_o, 1'b0);
    eoi_pri();
    chk("R10 eoi unblocks", int_o, 1'b1);
    expect_ack("R10 pending delivered", 4'd6, (PB & 8'hf8) | 8'd6);
  endtask

  task automatic t_secondary;
    do_reset(1'b0);
    irq_i[12] = 1'b1;
    tick(1);
    chk("R5 not yet at primary", int_o, 1'b0);
    tick(1);
    chk("R5 cascade raises int", int_o, 1'b1);
    expect_ack("R5 secondary ack", 4'd12, (SB & 8'hf8) | 8'd4);
    tick(1);
    chk("R11 int low after cascade ack", int_o, 1'b0);
  endtask

  task automatic t_spurious;
    do_reset(1'b0);
    expect_ack("R6 spurious primary", 4'd7, (PB & 8'hf8) | 8'd7);
    do_reset(1'b0);
    irq_i[10] = 1'b1;
    tick(2);
    chk("R7 cascade pending", int_o, 1'b1);
    mask_i[10] = 1'b1;
    tick(1);
    chk("R7 primary still requests", int_o, 1'b1);
    expect_ack("R7 spurious secondary", 4'd15, (SB & 8'hf8) | 8'd7);
  endtask

  task automatic t_mask;
    do_reset(1'b0);
    mask_i[4] = 1'b1;
    irq_i[4] = 1'b1;
    tick(2);
    chk("R13 masked no int", int_o, 1'b0);
    mask_i[4] = 1'b0;
    tick(1);
    chk("R13 unmask int", int_o, 1'b1);
    expect_ack("R13 unmasked delivered", 4'd4, (PB & 8'hf8) | 8'd4);
  endtask

  task automatic t_nest(input logic nest);
    do_reset(nest);
    irq_i[13] = 1'b1;
    tick(2);
    expect_ack("R8 first secondary", 4'd13, (SB & 8'hf8) | 8'd5);
    irq_i[9] = 1'b1;
    tick(3);
    chk(nest ? "R8 nested int" : "R8 blocked int", int_o, nest);
    if (nest) expect_ack("R8 nested ack", 4'd9, (SB & 8'hf8) | 8'd1);
  endtask

  task automatic t_line2;
    do_reset(1'b0);
    irq_i[2] = 1'b1;
    tick(3);
    chk("R9 line2 ignored", int_o, 1'b0);
    expect_ack("R9 line2 no winner", 4'd7, (PB & 8'hf8) | 8'd7);
  endtask

  initial begin
    #(5ns * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_primary();
    t_priority();
    t_secondary();
    t_spurious();
    t_mask();
    t_nest(1'b0);
    t_nest(1'b1);
    t_line2();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule